// File: doc/BRIEF.md
# Descriptor-Driven Configuration Transfer Engine

This block serves a table of read-only configuration items to firmware through memory. Software places a 16-byte descriptor in memory and pulses `start` with the descriptor's address. The engine fetches the descriptor one byte per beat through a simple memory master port. The descriptor holds a big-endian control word at the lowest address, a big-endian 32-bit length and a big-endian 64-bit target address. The engine can switch to another item, and then either copy bytes of the current item to the target address or move the item offset forward without touching memory. When it is done it writes a status word back over the descriptor's control word.

The current item selector and the current byte offset are held in one place. A legacy selector write, `sel_wr`, changes them as well. The engine and the legacy port therefore see the same read position. Items are generated inside the block, each with a fixed length. Item 0 is empty and selectors at or above the item count are invalid. A feature word reports that this engine is present.

Top module: `cfgdma_engine`

## Requirements
- R1: After reset `busy` and `mem_req` are low, the selector and offset are 0, and `feature_word` reads 3 (bit 0 for the legacy port, bit 1 for this engine).
- R2: A started operation reads the 16 descriptor bytes in ascending address order from the descriptor address. It holds each request and its address until the beat is acknowledged. The first four bytes form the control word, most significant byte first.
- R3: Control word bit 1 requests a read and bit 2 requests a skip. Read wins when both bits are set. When neither bit is set, no bytes are moved and the status is 0.
- R4: When control bit 3 is set, bits 31:16 select the item before any transfer, and the offset returns to 0.
- R5: A read writes the current item's bytes from the current offset to ascending target addresses. The offset advances by one for each item byte sent.
- R6: A skip advances the offset by the smaller of the length and the bytes left in the item, in one step, with no memory writes.
- R7: When the selector is invalid, the item is empty or the offset has reached the item length, a read writes zero bytes for the whole remaining length.
- R8: A read longer than the bytes left in the item first sends the remaining item bytes and then zero bytes for the rest of the length.
- R9: An error on any descriptor fetch beat ends the fetch at once. No transfer follows, and the status 1 is written back.
- R10: The status is written as four bytes at the descriptor address, big-endian: 0 on success, or 1 after a failed data write. The first failed data write ends the transfer.
- R11: `busy` rises in the cycle after an accepted `start` and falls after the last status beat. A `start` pulse while busy is ignored.
- R12: A legacy selector write while idle sets the selector and clears the offset. While busy it is ignored. When it coincides with `start` it takes effect before the descriptor is used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse, sampled while idle |
| desc_addr | input | ADDR_W | Descriptor address, sampled with start |
| busy | output | 1 | Operation in progress |
| sel_wr | input | 1 | Legacy selector write strobe |
| sel_idx | input | 16 | Legacy selector value |
| cur_sel | output | 16 | Current item selector |
| cur_off | output | 32 | Current byte offset within the item |
| feature_word | output | 32 | Feature bitmap, constant 3 |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | Beat is a write |
| mem_addr | output | ADDR_W | Beat byte address |
| mem_wdata | output | 8 | Write byte |
| mem_rdata | input | 8 | Read byte, valid with mem_ack |
| mem_ack | input | 1 | Beat accepted this cycle |
| mem_err | input | 1 | Accepted beat failed |

## Verification
The legacy selector write and the engine's own use of the selector can land in the same cycle. This happens when `sel_wr` rises together with `start`, and again when `sel_wr` is pulsed while a read is streaming bytes. The bench drives both cases at the ports. In the first case it expects the descriptor to read from the legacy-chosen item. In the second it expects the byte stream and the final offset to be exactly those of an undisturbed run. A `start` pulse during an operation is checked the same way: the scoreboard must see no extra beats.

// File: rtl/cfgdma_pkg.sv
package cfgdma_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_DECODE, ST_XFER, ST_WB
  } seq_state_t;

  typedef struct packed {
    logic [31:0] ctl;
    logic [31:0] len;
    logic [63:0] tgt;
  } desc_t;

  localparam int unsigned CB_RD   = 1;
  localparam int unsigned CB_SKIP = 2;
  localparam int unsigned CB_SEL  = 3;
  localparam int unsigned DESC_BYTES = 16;
  localparam int unsigned STAT_BYTES = 4;

  // item k holds 3k+2 bytes, item 0 is empty, k >= n is invalid
  function automatic logic [31:0] item_len(logic [15:0] idx, int unsigned n);
    if (idx == 16'd0 || 32'(idx) >= n) return 32'd0;
    return 32'(idx) * 32'd3 + 32'd2;
  endfunction

  function automatic logic [7:0] item_byte(logic [15:0] idx, logic [31:0] off);
    logic [31:0] v;
    v = ({16'd0, idx} << 5) ^ (off * 32'd3 + 32'd1);
    return v[7:0];
  endfunction

  function automatic logic [31:0] min32(logic [31:0] a, logic [31:0] b);
    return (a < b) ? a : b;
  endfunction

  // byte i of a big-endian 32-bit word
  function automatic logic [7:0] be_byte(logic [31:0] w, logic [1:0] i);
    return 8'(w >> (8 * (3 - int'(i))));
  endfunction

endpackage

// File: rtl/cfgdma_item_store.sv
module cfgdma_item_store
  import cfgdma_pkg::*;
#(
  parameter int unsigned NUM_ITEMS = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sel_load,
  input  logic [15:0] sel_val,
  input  logic        adv,
  input  logic [31:0] adv_amt,
  output logic [15:0] cur_sel,
  output logic [31:0] cur_off,
  output logic [31:0] avail,
  output logic        in_range,
  output logic [7:0]  cur_byte
);

  logic [31:0] cur_len;

  assign cur_len  = item_len(cur_sel, NUM_ITEMS);
  assign in_range = cur_off < cur_len;
  assign avail    = in_range ? (cur_len - cur_off) : 32'd0;
  assign cur_byte = item_byte(cur_sel, cur_off);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_sel <= '0;
      cur_off <= '0;
    end else if (sel_load) begin
      cur_sel <= sel_val;
      cur_off <= '0;
    end else if (adv) begin
      cur_off <= cur_off + adv_amt;
    end
  end

  // R4: a selection always restarts the item at offset 0
  p_sel_clears_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sel_load |=> cur_off == 32'd0);

  // R6: the offset never runs past the end of the item
  p_off_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cur_off <= cur_len);

endmodule

// File: rtl/cfgdma_seq.sv
module cfgdma_seq
  import cfgdma_pkg::*;
#(
  parameter int unsigned ADDR_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] desc_addr,
  output logic              busy,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata,
  input  logic              mem_ack,
  input  logic              mem_err,
  output logic              eng_sel,
  output logic [15:0]       eng_idx,
  output logic              adv,
  output logic [31:0]       adv_amt,
  input  logic [31:0]       avail,
  input  logic              in_range,
  input  logic [7:0]        cur_byte
);

  localparam int unsigned DBUF_W = DESC_BYTES * 8;
  localparam int unsigned CNT_W  = $clog2(DESC_BYTES);

  seq_state_t        state;
  logic [CNT_W-1:0]  cnt;
  logic [DBUF_W-1:0] dbuf;
  logic [ADDR_W-1:0] dptr;
  logic [ADDR_W-1:0] tgt;
  logic [31:0]       rem;
  logic              rd_mode;
  logic              status;
  desc_t             dsc;
  logic              beat;
  logic              xfer_wr;

  assign dsc  = desc_t'(dbuf);
  assign busy = state != ST_IDLE;
  assign beat = mem_req && mem_ack;

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = dptr + ADDR_W'(cnt);
    mem_wdata = 8'd0;
    eng_sel   = 1'b0;
    eng_idx   = dsc.ctl[31:16];
    adv       = 1'b0;
    adv_amt   = 32'd1;
    xfer_wr   = 1'b0;
    unique case (state)
      ST_FETCH: mem_req = 1'b1;
      ST_DECODE: eng_sel = dsc.ctl[CB_SEL];
      ST_XFER: begin
        if (rem != 32'd0) begin
          if (rd_mode) begin
            xfer_wr   = 1'b1;
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = tgt;
            mem_wdata = in_range ? cur_byte : 8'd0;
            adv       = beat && in_range;
          end else begin
            adv     = 1'b1;
            adv_amt = min32(rem, avail);
          end
        end
      end
      ST_WB: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_wdata = be_byte({31'd0, status}, cnt[1:0]);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      dbuf    <= '0;
      dptr    <= '0;
      tgt     <= '0;
      rem     <= '0;
      rd_mode <= 1'b0;
      status  <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (start) begin
          dptr  <= desc_addr;
          cnt   <= '0;
          state <= ST_FETCH;
        end
        ST_FETCH: if (beat) begin
          if (mem_err) begin
            status <= 1'b1;
            cnt    <= '0;
            state  <= ST_WB;
          end else begin
            dbuf <= {dbuf[DBUF_W-9:0], mem_rdata};
            cnt  <= cnt + 1'b1;
            if (cnt == CNT_W'(DESC_BYTES - 1)) state <= ST_DECODE;
          end
        end
        ST_DECODE: begin
          rd_mode <= dsc.ctl[CB_RD];
          rem     <= (dsc.ctl[CB_RD] || dsc.ctl[CB_SKIP]) ? dsc.len : 32'd0;
          tgt     <= dsc.tgt[ADDR_W-1:0];
          status  <= 1'b0;
          cnt     <= '0;
          state   <= ST_XFER;
        end
        ST_XFER: begin
          if (rem == 32'd0) begin
            cnt   <= '0;
            state <= ST_WB;
          end else if (!rd_mode) begin
            rem <= 32'd0;
          end else if (beat) begin
            tgt <= tgt + 1'b1;
            rem <= rem - 32'd1;
            if (mem_err) begin
              status <= 1'b1;
              cnt    <= '0;
              state  <= ST_WB;
            end
          end
        end
        ST_WB: if (beat) begin
          cnt <= cnt + 1'b1;
          if (cnt == CNT_W'(STAT_BYTES - 1)) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R11: no memory traffic while idle
  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req);

  // R11: an accepted start makes the engine busy in the next cycle
  p_start_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> busy);

  // R2: a pending beat keeps its request and address
  p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr));

  // R7: data writes outside the item carry zero
  p_zero_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_wr && !in_range |-> mem_wdata == 8'd0);

  // R6: a skip never issues memory beats
  p_skip_no_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_XFER && !rd_mode |-> !mem_req);

endmodule

// File: rtl/cfgdma_engine.sv
module cfgdma_engine
  import cfgdma_pkg::*;
#(
  parameter int unsigned NUM_ITEMS = 4,
  parameter int unsigned ADDR_W    = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] desc_addr,
  output logic              busy,
  input  logic              sel_wr,
  input  logic [15:0]       sel_idx,
  output logic [15:0]       cur_sel,
  output logic [31:0]       cur_off,
  output logic [31:0]       feature_word,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata,
  input  logic              mem_ack,
  input  logic              mem_err
);

  localparam logic [31:0] FEATURES = 32'h0000_0003;

  logic        eng_sel;
  logic [15:0] eng_idx;
  logic        adv;
  logic [31:0] adv_amt;
  logic [31:0] avail;
  logic        in_range;
  logic [7:0]  cur_byte;
  logic        legacy_ok;
  logic        sel_load;
  logic [15:0] sel_val;

  assign feature_word = FEATURES;
  assign legacy_ok    = sel_wr && !busy;
  assign sel_load     = eng_sel || legacy_ok;
  assign sel_val      = eng_sel ? eng_idx : sel_idx;

  cfgdma_item_store #(.NUM_ITEMS(NUM_ITEMS)) store_i (
    .clk(clk), .rst_n(rst_n),
    .sel_load(sel_load), .sel_val(sel_val),
    .adv(adv), .adv_amt(adv_amt),
    .cur_sel(cur_sel), .cur_off(cur_off),
    .avail(avail), .in_range(in_range), .cur_byte(cur_byte)
  );

  cfgdma_seq #(.ADDR_W(ADDR_W)) seq_i (
    .clk(clk), .rst_n(rst_n),
    .start(start), .desc_addr(desc_addr), .busy(busy),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_ack(mem_ack), .mem_err(mem_err),
    .eng_sel(eng_sel), .eng_idx(eng_idx),
    .adv(adv), .adv_amt(adv_amt),
    .avail(avail), .in_range(in_range), .cur_byte(cur_byte)
  );

  // R12: a legacy write during an operation leaves the selector alone
  p_legacy_ignored_r12: assert property (@(posedge clk) disable iff (!rst_n)
    sel_wr && busy && !eng_sel |=> $stable(cur_sel));

endmodule

// File: tb/cfgdma_engine_tb_top.sv
module cfgdma_engine_tb_top;

  localparam int CLK_NS = 20;

  typedef struct {
    bit         we;
    logic [7:0] a;
    logic [7:0] d;
    string      tag;
  } beat_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [63:0] desc_addr = '0;
  logic        busy;
  logic        sel_wr = 1'b0;
  logic [15:0] sel_idx = '0;
  logic [15:0] cur_sel;
  logic [31:0] cur_off;
  logic [31:0] feature_word;
  logic        mem_req, mem_we;
  logic [63:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = '0;
  logic        mem_ack = 1'b0;
  logic        mem_err = 1'b0;

  logic [7:0] mem [0:255];
  beat_t      q[$];
  int         n_tests = 0;
  int         n_fail = 0;
  int         cyc = 0;
  bit         err_en = 0;
  logic [7:0] err_lo = 0, err_hi = 0;
  logic [15:0] m_sel = 0;
  logic [31:0] m_off = 0;
  bit         done = 0;

  always #(CLK_NS/2) clk = ~clk;

  cfgdma_engine dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .desc_addr(desc_addr),
    .busy(busy), .sel_wr(sel_wr), .sel_idx(sel_idx), .cur_sel(cur_sel),
    .cur_off(cur_off), .feature_word(feature_word), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack), .mem_err(mem_err)
  );

  function automatic bit in_err(logic [7:0] a);
    return err_en && a >= err_lo && a <= err_hi;
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // memory model and scoreboard monitor, away from the active edge
  always @(negedge clk) begin
    cyc++;
    mem_ack   = mem_req && (cyc % 3 != 1);
    mem_err   = mem_ack && in_err(mem_addr[7:0]);
    mem_rdata = mem[mem_addr[7:0]];
    if (mem_ack) begin
      n_tests++;
      if (q.size() == 0) begin
        n_fail++;
        $display("FAIL R11 unexpected beat actual=we%0d@%0h expected=none", mem_we, mem_addr);
      end else begin
        beat_t e;
        e = q.pop_front();
        if (mem_we !== e.we || mem_addr !== {56'd0, e.a} || (e.we && mem_wdata !== e.d)) begin
          n_fail++;
          $display("FAIL %s beat actual=we%0d@%0h=%0h expected=we%0d@%0h=%0h",
                   e.tag, mem_we, mem_addr, mem_wdata, e.we, e.a, e.d);
        end
      end
      if (mem_we && !mem_err) mem[mem_addr[7:0]] = mem_wdata;
    end
  end

  function automatic logic [31:0] b_len(logic [15:0] k);
    if (k >= 1 && k <= 3) return 32'(k) * 3 + 2;
    return 0;
  endfunction

  function automatic logic [7:0] b_byte(logic [15:0] k, logic [31:0] o);
    logic [7:0] hi, lo;
    hi = {k[2:0], 5'd0};
    lo = 8'(o + o + o + 1);
    return hi ^ lo;
  endfunction

  function automatic void push(bit we, logic [7:0] a, logic [7:0] d, string tag);
    beat_t b;
    b.we = we; b.a = a; b.d = d; b.tag = tag;
    q.push_back(b);
  endfunction

  // builds the descriptor, predicts every beat, runs the op, checks the results
  task automatic run_op(string tag, logic [7:0] da, logic [31:0] ctl,
                        logic [31:0] len, logic [7:0] tgt,
                        bit legacy_with_start, logic [15:0] legacy_val);
    bit ferr;
    logic [31:0] st;
    logic [31:0] avl;
    for (int i = 0; i < 4; i++) begin
      mem[da + 8'(i)]     = ctl[8*(3-i) +: 8];
      mem[da + 8'(4 + i)] = len[8*(3-i) +: 8];
    end
    for (int i = 0; i < 8; i++) mem[da + 8'(8 + i)] = (i == 7) ? tgt : 8'd0;
    if (legacy_with_start) begin m_sel = legacy_val; m_off = 0; end
    ferr = 0; st = 0;
    for (int i = 0; i < 16; i++) begin
      push(0, da + 8'(i), 0, tag);
      if (in_err(da + 8'(i))) begin ferr = 1; break; end
    end
    if (ferr) st = 1;
    else begin
      if (ctl[3]) begin m_sel = ctl[31:16]; m_off = 0; end
      if (ctl[1]) begin
        for (int k = 0; k < int'(len); k++) begin
          bit inr;
          inr = m_off < b_len(m_sel);
          push(1, tgt + 8'(k), inr ? b_byte(m_sel, m_off) : 8'd0, tag);
          if (inr) m_off++;
          if (in_err(tgt + 8'(k))) begin st = 1; break; end
        end
      end else if (ctl[2]) begin
        avl = (m_off < b_len(m_sel)) ? b_len(m_sel) - m_off : 0;
        m_off += (len < avl) ? len : avl;
      end
    end
    for (int j = 0; j < 4; j++) push(1, da + 8'(j), (j == 3) ? st[7:0] : 8'd0, tag);
    @(negedge clk);
    desc_addr = {56'd0, da};
    start = 1'b1;
    if (legacy_with_start) begin sel_wr = 1'b1; sel_idx = legacy_val; end
    @(negedge clk);
    start = 1'b0; sel_wr = 1'b0;
    chk({tag, " R11 busy after start"}, busy, 1);
    begin
      int guard = 0;
      while (busy && guard < 2000) begin @(negedge clk); guard++; end
    end
    chk({tag, " R11 busy falls"}, busy, 0);
    chk({tag, " beats left"}, q.size(), 0);
    q.delete();
    chk({tag, " R4 selector"}, cur_sel, m_sel);
    chk({tag, " R5 offset"}, cur_off, m_off);
    chk({tag, " R10 status word"}, {mem[da], mem[da+1], mem[da+2], mem[da+3]}, st);
  endtask

  initial begin
    #(CLK_NS * 150000);
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'hA5;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", busy, 0);
    chk("R1 mem_req", mem_req, 0);
    chk("R1 selector", cur_sel, 0);
    chk("R1 offset", cur_off, 0);
    chk("R1 feature word", feature_word, 32'h3);

    // R3 R4 R5: select item 2 and read 5 bytes
    run_op("R5 select+read", 8'h10, 32'h0002_000A, 5, 8'h80, 0, 0);
    // R8: read 6 with 3 item bytes left, then zeros
    run_op("R8 split read", 8'h10, 32'h0000_0002, 6, 8'h80, 0, 0);
    // R6: select item 3, skip 4, then a huge skip capped at the item end
    run_op("R6 skip", 8'h20, 32'h0003_000C, 4, 8'h80, 0, 0);
    run_op("R6 skip capped", 8'h20, 32'h0000_0004, 32'h1000_0000, 8'h80, 0, 0);
    // R7: invalid item, then empty item
    run_op("R7 invalid item", 8'h30, 32'h0009_000A, 4, 8'h90, 0, 0);
    run_op("R7 empty item", 8'h30, 32'h0000_000A, 3, 8'h90, 0, 0);
    // R3: read and skip both set, read wins
    run_op("R3 read wins", 8'h40, 32'h0001_000E, 3, 8'hA0, 0, 0);
    // R3: neither bit set, select only
    run_op("R3 no transfer", 8'h40, 32'h0002_0008, 5, 8'hA0, 0, 0);
    // R9: descriptor fetch error at byte 5
    err_en = 1; err_lo = 8'h55; err_hi = 8'h55;
    run_op("R9 fetch error", 8'h50, 32'h0001_000A, 4, 8'hB0, 0, 0);
    // R10: data write error on the third byte stops the transfer
    err_lo = 8'hC2; err_hi = 8'hC2;
    run_op("R10 write error", 8'h60, 32'h0001_000A, 5, 8'hC0, 0, 0);
    err_en = 0;
    // R12: legacy write together with start picks the item read
    run_op("R12 legacy with start", 8'h70, 32'h0000_0002, 4, 8'hD0, 1, 16'd3);

    // R11 R12: start and legacy write during a long read are ignored
    fork
      run_op("R12 legacy while busy", 8'h10, 32'h0002_000A, 12, 8'hE0, 0, 0);
      begin
        repeat (30) @(negedge clk);
        sel_wr = 1'b1; sel_idx = 16'd1; start = 1'b1; desc_addr = 64'h20;
        @(negedge clk);
        sel_wr = 1'b0; start = 1'b0;
      end
    join
    repeat (10) @(negedge clk);
    chk("R11 no second op", busy, 0);

    // R12: legacy write while idle
    @(negedge clk);
    sel_wr = 1'b1; sel_idx = 16'd3;
    @(negedge clk);
    sel_wr = 1'b0;
    chk("R12 idle legacy selector", cur_sel, 16'd3);
    chk("R12 idle legacy offset", cur_off, 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule